// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block drives the command, bank and address lines of a reduced-latency DRAM through its start-up sequence once the system reports that supplies and clocks are stable. A single start pulse launches the run. The block first holds the bus idle for a stabilisation period. That period is never shorter than the lock time of the device's delay-locked loop. It then issues two throw-away mode-register writes to train the device, followed by the real mode-register write. In multiplexed-address mode it adds a second write that carries the upper half of the mode bitmap.

After one more mode-register recovery gap, the block auto-refreshes every bank exactly once with a fixed spacing between refreshes. It then waits one row-cycle time and raises a done flag. The flag tells the memory controller that normal traffic may begin. A later start pulse given while done is high runs the whole sequence again, including the full lock wait. This covers re-initialisation after a clock stop or a DLL reset.

The wait lengths are taken from inputs, so one netlist serves several speed grades. The mode values, the multiplexed-mode flag and the wait lengths are all sampled when the start pulse is accepted.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, `done_o` is 0 and the command output is NOP. No command is issued until `start_i` is seen high at a clock edge.
- R2: The command is encoded as 2'b00 = NOP, 2'b01 = mode-register set, 2'b10 = auto-refresh. On every NOP cycle `bank_o` and `addr_o` are zero. No command other than those listed in R3 to R8 ever appears.
- R3: The start edge counts as cycle 0. The first command appears in cycle W, where W = max(`stable_cyc_i`, DLL_MIN_WAIT). DLL_MIN_WAIT defaults to 1024.
- R4: Mode-register sets are issued in cycles W, W+1 and W+2. All three use bank 0 and address = `mode_lo_i`.
- R5: When `mux_mode_i` is 1, a fourth mode-register set with address = `mode_hi_i` and bank 0 is issued in cycle W+2+M. M = `mrsc_cyc_i`, and a value of 0 is treated as 1.
- R6: The first auto-refresh is issued M cycles after the last mode-register set.
- R7: Exactly NUM_BANKS (8) auto-refreshes are issued. They address banks 0, 1, ... 7 in ascending order, use address 0, and are spaced exactly REF_GAP (2048) cycles apart.
- R8: `done_o` rises R cycles after the last auto-refresh, where R = `rc_cyc_i` and 0 is treated as 1. It stays high, with NOP on the bus, until a new start.
- R9: A start pulse that arrives while a sequence is running is ignored and does not shift any later command.
- R10: A start pulse while `done_o` is high clears `done_o` in cycle 0 and replays the full sequence from R3.
- R11: Pulling `rst_n` low in the middle of a sequence returns the block to idle. `done_o` is then 0 and only NOPs are issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch (or relaunch) the start-up sequence |
| mux_mode_i | input | 1 | Multiplexed-address mode: send the second mode-register half |
| mode_lo_i | input | ADDR_W | Mode bitmap, first (or only) half |
| mode_hi_i | input | ADDR_W | Mode bitmap, second half |
| stable_cyc_i | input | CNT_W | Requested stabilisation wait in cycles |
| mrsc_cyc_i | input | CNT_W | Mode-register recovery time in cycles |
| rc_cyc_i | input | CNT_W | Row-cycle time in cycles |
| cmd_o | output | 2 | Command code (see R2) |
| bank_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | Sequence complete, device ready |

## Verification
Every result has a fixed cycle offset from the start edge: W for the first write, W+1 and W+2 for the next two, W+2+M for the upper half, L+M for the first refresh, then 2048 cycles per bank, and R cycles more for done. The outputs are decoded from state registers, so a command appears in the cycle that follows the edge that entered its state. The bench counts cycles from the start edge and samples at the falling edge of each cycle. It compares command, bank, address and done in every cycle against a schedule it builds from these formulas. Every expected event is counted as a check of its own, and any stray command or early done in the remaining cycles fails one summary check per run.

// File: rtl/dram_init_pkg.sv
// Shared types for the DRAM start-up sequencer.
// Assumes: a two-bit command bus; the codes are fixed by the requirements.
package dram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_MRS  = 2'b01,
        CMD_AREF = 2'b10
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAB,
        ST_DUMMY0,
        ST_DUMMY1,
        ST_MRS_LO,
        ST_GAP_MRS,
        ST_MRS_HI,
        ST_GAP_REF0,
        ST_REF,
        ST_GAP_REF,
        ST_RC,
        ST_DONE
    } state_e;

endpackage

// File: rtl/dram_init_timer.sv
// Down-counter for every wait period of the sequencer.
// A load sets the count; the counter then steps down to zero and stays there.
// Assumes: the FSM loads (cycles_in_wait - 1) on the edge that enters a wait
// state and leaves that state on the edge where expired_o is high.
module dram_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, else decrement down to zero.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_STEPS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/dram_init_fsm.sv
// Sequence controller: walks the stabilisation wait, the training and real
// mode-register writes, the per-bank refreshes and the final row-cycle wait.
// Assumes: configuration inputs are sampled only when a start is accepted;
// REF_GAP >= 2; DLL_MIN_WAIT fits in CNT_W bits.
module dram_init_fsm
    import dram_init_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int NUM_BANKS    = 8,
    parameter int REF_GAP      = 2048,
    parameter int DLL_MIN_WAIT = 1024,
    localparam int BANK_W      = $clog2(NUM_BANKS)
) (
    input  logic              clk_i,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mux_mode_i,
    input  logic [CNT_W-1:0]  stable_cyc_i,
    input  logic [CNT_W-1:0]  mrsc_cyc_i,
    input  logic [CNT_W-1:0]  rc_cyc_i,
    output state_e            state_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              accept_o
);

    localparam logic [CNT_W-1:0]  ONE_C      = CNT_W'(1);
    localparam logic [CNT_W-1:0]  TWO_C      = CNT_W'(2);
    localparam logic [CNT_W-1:0]  DLL_MIN_C  = CNT_W'(DLL_MIN_WAIT);
    localparam logic [CNT_W-1:0]  GAP_LOAD_C = CNT_W'(REF_GAP - 2);
    localparam logic [BANK_W-1:0] LAST_BANK  = BANK_W'(NUM_BANKS - 1);
    localparam int                SINCE_W    = CNT_W + 2;

    state_e            state_q, state_d;
    logic              mux_q;
    logic [CNT_W-1:0]  mrsc_q, rc_q;
    logic [BANK_W-1:0] bank_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [CNT_W-1:0]  wait_eff;
    logic [CNT_W-1:0]  mrsc_eff;
    logic [CNT_W-1:0]  rc_eff;
    logic              accept;

    // Stabilisation length never below the DLL lock time; zero gaps become one.
    always_comb begin
        wait_eff = (stable_cyc_i < DLL_MIN_C) ? DLL_MIN_C : stable_cyc_i;
        mrsc_eff = (mrsc_cyc_i == '0) ? ONE_C : mrsc_cyc_i;
        rc_eff   = (rc_cyc_i == '0) ? ONE_C : rc_cyc_i;
    end

    assign accept = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

    dram_init_timer #(.CNT_W(CNT_W)) timer_i (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    // Next-state and timer-load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d  = ST_STAB;
                    tmr_load = 1'b1;
                    tmr_val  = wait_eff - ONE_C;
                end
            end
            ST_STAB:    if (tmr_expired) state_d = ST_DUMMY0;
            ST_DUMMY0:  state_d = ST_DUMMY1;
            ST_DUMMY1:  state_d = ST_MRS_LO;
            ST_MRS_LO: begin
                if (mux_q) begin
                    if (mrsc_q > ONE_C) begin
                        state_d  = ST_GAP_MRS;
                        tmr_load = 1'b1;
                        tmr_val  = mrsc_q - TWO_C;
                    end else begin
                        state_d = ST_MRS_HI;
                    end
                end else if (mrsc_q > ONE_C) begin
                    state_d  = ST_GAP_REF0;
                    tmr_load = 1'b1;
                    tmr_val  = mrsc_q - TWO_C;
                end else begin
                    state_d = ST_REF;
                end
            end
            ST_GAP_MRS: if (tmr_expired) state_d = ST_MRS_HI;
            ST_MRS_HI: begin
                if (mrsc_q > ONE_C) begin
                    state_d  = ST_GAP_REF0;
                    tmr_load = 1'b1;
                    tmr_val  = mrsc_q - TWO_C;
                end else begin
                    state_d = ST_REF;
                end
            end
            ST_GAP_REF0: if (tmr_expired) state_d = ST_REF;
            ST_REF: begin
                if (bank_q == LAST_BANK) begin
                    if (rc_q > ONE_C) begin
                        state_d  = ST_RC;
                        tmr_load = 1'b1;
                        tmr_val  = rc_q - TWO_C;
                    end else begin
                        state_d = ST_DONE;
                    end
                end else begin
                    state_d  = ST_GAP_REF;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LOAD_C;
                end
            end
            ST_GAP_REF: if (tmr_expired) state_d = ST_REF;
            ST_RC:      if (tmr_expired) state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration capture at start acceptance.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            mux_q  <= 1'b0;
            mrsc_q <= ONE_C;
            rc_q   <= ONE_C;
        end else if (accept) begin
            mux_q  <= mux_mode_i;
            mrsc_q <= mrsc_eff;
            rc_q   <= rc_eff;
        end
    end

    // Refresh bank pointer: cleared at start, steps after each refresh.
    always_ff @(posedge clk_i) begin
        if (!rst_n || accept) begin
            bank_q <= '0;
        end else if (state_q == ST_REF && bank_q != LAST_BANK) begin
            bank_q <= bank_q + 1'b1;
        end
    end

    assign state_o  = state_q;
    assign bank_o   = bank_q;
    assign accept_o = accept;

    // Checker-only counters: cycles since the accepted start, refreshes seen.
    logic [SINCE_W-1:0] since_q;
    logic [BANK_W:0]    refs_q;

    // Saturating cycle count since the last accepted start.
    always_ff @(posedge clk_i) begin
        if (!rst_n || accept)   since_q <= '0;
        else if (since_q != '1) since_q <= since_q + 1'b1;
    end

    // Number of refresh states since the last accepted start.
    always_ff @(posedge clk_i) begin
        if (!rst_n || accept)       refs_q <= '0;
        else if (state_q == ST_REF) refs_q <= refs_q + 1'b1;
    end

    AST_LOCK_WAIT_MET: assert property (@(posedge clk_i) disable iff (!rst_n)
        (state_q == ST_DUMMY0) |-> (since_q >= SINCE_W'(DLL_MIN_WAIT))); // R3

    AST_ALL_BANKS_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) != ST_DONE) |-> (refs_q == (BANK_W+1)'(NUM_BANKS))); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n)
        (start_i && state_q != ST_IDLE && state_q != ST_DONE && since_q != '1)
        |=> (since_q == $past(since_q) + 1'b1)); // R9

endmodule

// File: rtl/dram_init_cmd_enc.sv
// Output decoder: turns the controller state into command, bank, address and
// done. The mode bitmaps are captured when a start is accepted.
// Assumes: every output is a pure function of registered state (Moore style).
module dram_init_cmd_enc
    import dram_init_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BANK_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] mode_lo_i,
    input  logic [ADDR_W-1:0] mode_hi_i,
    input  state_e            state_i,
    input  logic [BANK_W-1:0] ref_bank_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    logic [ADDR_W-1:0] lo_q, hi_q;
    cmd_e              cmd;

    // Mode bitmap capture at start acceptance.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept_i) begin
            lo_q <= mode_lo_i;
            hi_q <= mode_hi_i;
        end
    end

    // State-to-bus decode; every non-command state drives NOP and zeros.
    always_comb begin
        cmd    = CMD_NOP;
        bank_o = '0;
        addr_o = '0;
        unique case (state_i)
            ST_DUMMY0, ST_DUMMY1, ST_MRS_LO: begin
                cmd    = CMD_MRS;
                addr_o = lo_q;
            end
            ST_MRS_HI: begin
                cmd    = CMD_MRS;
                addr_o = hi_q;
            end
            ST_REF: begin
                cmd    = CMD_AREF;
                bank_o = ref_bank_i;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign cmd_o  = cmd;
    assign done_o = (state_i == ST_DONE);

    AST_MRS_SEQ_BANK0: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cmd_o == CMD_MRS && $past(cmd_o) == CMD_MRS) |-> (bank_o == '0)); // R4

endmodule

// File: rtl/dram_init_seq.sv
// Top of the DRAM start-up sequencer: controller plus output decoder.
// Assumes: start_i is a single-cycle request; the device clock and supplies
// are already stable when it arrives.
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int CNT_W        = 16,
    parameter int NUM_BANKS    = 8,
    parameter int REF_GAP      = 2048,
    parameter int DLL_MIN_WAIT = 1024,
    localparam int BANK_W      = $clog2(NUM_BANKS)
) (
    input  logic              clk_i,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mux_mode_i,
    input  logic [ADDR_W-1:0] mode_lo_i,
    input  logic [ADDR_W-1:0] mode_hi_i,
    input  logic [CNT_W-1:0]  stable_cyc_i,
    input  logic [CNT_W-1:0]  mrsc_cyc_i,
    input  logic [CNT_W-1:0]  rc_cyc_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    state_e            state;
    logic [BANK_W-1:0] ref_bank;
    logic              accept;

    dram_init_fsm #(
        .CNT_W        (CNT_W),
        .NUM_BANKS    (NUM_BANKS),
        .REF_GAP      (REF_GAP),
        .DLL_MIN_WAIT (DLL_MIN_WAIT)
    ) fsm_i (
        .clk_i        (clk_i),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mux_mode_i   (mux_mode_i),
        .stable_cyc_i (stable_cyc_i),
        .mrsc_cyc_i   (mrsc_cyc_i),
        .rc_cyc_i     (rc_cyc_i),
        .state_o      (state),
        .bank_o       (ref_bank),
        .accept_o     (accept)
    );

    dram_init_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) enc_i (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .mode_lo_i  (mode_lo_i),
        .mode_hi_i  (mode_hi_i),
        .state_i    (state),
        .ref_bank_i (ref_bank),
        .cmd_o      (cmd_o),
        .bank_o     (bank_o),
        .addr_o     (addr_o),
        .done_o     (done_o)
    );

    AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R8

    AST_REINIT_DROPS_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o); // R10

    AST_AREF_SPACED: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cmd_o == CMD_AREF) |=> (cmd_o == CMD_NOP)); // R7

    AST_DONE_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(done_o) |-> ($past(cmd_o) != CMD_MRS)); // R8

endmodule

// File: tb/dram_init_seq_tb_top.sv
// Self-checking bench: builds the expected command schedule from the
// requirement formulas and compares every cycle of every run.
module dram_init_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 20;
    localparam int CW         = 16;
    localparam int GAP        = 2048;
    localparam int DLL_MIN    = 1024;
    localparam int NB         = 8;
    localparam int N_VEC      = 4;
    // Columns: stable cycles, tMRSC, tRC, multiplexed flag, restart cycle (-1 none)
    localparam int VEC [N_VEC][5] = '{
        '{0,    4,  8, 0, -1},
        '{2000, 1,  1, 1, -1},
        '{1500, 0,  0, 1, 100},
        '{1024, 16, 5, 0, -1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mux = 1'b0;
    logic [AW-1:0] lo = '0;
    logic [AW-1:0] hi = '0;
    logic [CW-1:0] stab = '0;
    logic [CW-1:0] mrsc = '0;
    logic [CW-1:0] rc = '0;
    logic [1:0]    cmd;
    logic [2:0]    bank;
    logic [AW-1:0] addr;
    logic          done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_init_seq dut_i (
        .clk_i        (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .mux_mode_i   (mux),
        .mode_lo_i    (lo),
        .mode_hi_i    (hi),
        .stable_cyc_i (stab),
        .mrsc_cyc_i   (mrsc),
        .rc_cyc_i     (rc),
        .cmd_o        (cmd),
        .bank_o       (bank),
        .addr_o       (addr),
        .done_o       (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One full sequence; the start pulse is taken at the next edge (cycle 0).
    task automatic run_seq(input int st, input int m, input int r, input bit mx,
                           input int restart_at, input logic [AW-1:0] vlo,
                           input logic [AW-1:0] vhi, input bit reinit);
        int w, me, re, last_mrs, first_ref, done_at, bad, bad_n;
        longint bad_act, bad_exp;
        w  = (st < DLL_MIN) ? DLL_MIN : st;
        me = (m < 1) ? 1 : m;
        re = (r < 1) ? 1 : r;
        last_mrs  = mx ? (w + 2 + me) : (w + 2);
        first_ref = last_mrs + me;
        done_at   = first_ref + (NB - 1) * GAP + re;
        bad = 0; bad_n = -1; bad_act = 0; bad_exp = 0;
        stab = CW'(st); mrsc = CW'(m); rc = CW'(r); mux = mx; lo = vlo; hi = vhi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= done_at + 4; n++) begin
            logic [1:0]    ec;
            logic [2:0]    eb;
            logic [AW-1:0] ea;
            bit            ev;
            string         tag;
            start = (n == restart_at);
            ec = 2'b00; eb = '0; ea = '0; ev = 1'b0; tag = "R2";
            if (n == w) begin
                ec = 2'b01; ea = vlo; ev = 1'b1; tag = "R3";
            end else if (n == w + 1 || n == w + 2) begin
                ec = 2'b01; ea = vlo; ev = 1'b1; tag = "R4";
            end else if (mx && n == w + 2 + me) begin
                ec = 2'b01; ea = vhi; ev = 1'b1; tag = "R5";
            end else begin
                for (int b = 0; b < NB; b++) begin
                    if (n == first_ref + b * GAP) begin
                        ec = 2'b10; eb = 3'(b); ev = 1'b1;
                        tag = (b == 0) ? "R6" : "R7";
                    end
                end
            end
            if (ev) begin
                chk({cmd, bank, addr} == {ec, eb, ea}, tag, "command/bank/addr",
                    longint'({cmd, bank, addr}), longint'({ec, eb, ea}));
            end else if ({cmd, bank, addr} != {ec, eb, ea}) begin
                bad++;
                if (bad_n < 0) begin
                    bad_n = n; bad_act = longint'({cmd, bank, addr});
                    bad_exp = longint'({ec, eb, ea});
                end
            end
            if (n == 0 && reinit) begin
                chk(done == 1'b0, "R10", "done cleared by restart", done, 0);
            end else if (n == done_at - 1) begin
                chk(done == 1'b0, "R8", "done one cycle early", done, 0);
            end else if (n == done_at) begin
                chk(done == 1'b1, "R8", "done after row cycle", done, 1);
            end else if (done != (n >= done_at)) begin
                bad++;
                if (bad_n < 0) begin
                    bad_n = n; bad_act = done; bad_exp = (n >= done_at);
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(bad == 0, (restart_at >= 0) ? "R9" : "R2", "idle cycles / stray command",
            bad_act, bad_exp);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int quiet;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(cmd == 2'b00, "R1", "command in reset", cmd, 0);
        rst_n = 1'b1;
        quiet = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cmd != 2'b00 || done) quiet++;
        end
        chk(quiet == 0, "R1", "no command without start", quiet, 0);

        // Table walk: each row after the first relaunches from done (R10).
        for (int k = 0; k < N_VEC; k++) begin
            run_seq(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3] != 0, VEC[k][4],
                    AW'(32'h0A5C3 + k), AW'(32'hF0F0F ^ k), k > 0);
        end

        // R11: reset in the middle of the refresh phase
        stab = '0; mrsc = CW'(4); rc = CW'(8); mux = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3000) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && cmd == 2'b00, "R11", "reset mid-run",
            longint'({done, cmd}), 0);
        rst_n = 1'b1;
        quiet = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (cmd != 2'b00 || done) quiet++;
        end
        chk(quiet == 0, "R11", "idle after mid-run reset", quiet, 0);

        // R1: a fresh start after the reset runs normally
        run_seq(0, 2, 3, 1, -1, 20'h12345, 20'h6789A, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule